// File: doc/BRIEF.md
# Floppy Controller Status Byte and Interrupt Request

This block sits at the host side of a floppy disk controller. It holds the last command byte that the host wrote. From the upper nibble of that byte it works out the class of the command, and it tells the command sequencers through a one-cycle start pulse that a new command has arrived. It tracks the busy and data-request flags. When the host strobes a status read, it captures an 8-bit status byte. Some bits of that byte are shared, and their meaning depends on the class of the command in progress. For stepping-type commands and force-interrupt commands, those bits show live drive lines. For sector and track commands, they show transfer and error flags.

The block also drives the interrupt request line. A completion pulse from a sequencer sets a latched interrupt, and a status read or a new command clears it. A force-interrupt command can do one of two things. It can raise a sticky interrupt that only another force-interrupt with an empty condition field removes, or it can arm a one-shot interrupt that fires on the next rising edge of the index line. Stepping, sector transfer and the data path belong to the sequencers.

Top module: `fdc_status_irq`

## Requirements
- R1: A write strobe loads the command byte, which appears on `cmd_q` in the next cycle. Upper nibble 0x0–0x7 is the stepping class, 0x8–0xB is the sector class, 0xC, 0xE and 0xF are the track class, and 0xD is force-interrupt. A write of any class other than force-interrupt sets busy and pulses `cmd_start` high for exactly one cycle.
- R2: A status read strobe captures the status byte into `stat_q`, valid from the next cycle. Bit 0 is busy and bit 7 is the inverse of `drv_ready`, both as they stood at the strobe.
- R3: While the stepping or force-interrupt class is held, the status bits are: 1 = index line, 2 = track-zero line, 3 = CRC error, 4 = seek error, 5 = head-loaded line, 6 = write-protect line.
- R4: While the sector or track class is held, the status bits are: 1 = DRQ, 2 = lost data, 3 = CRC error, 4 = record not found, 5 = record type, 6 = write-protect error.
- R5: A `seq_done` pulse sets the interrupt and clears busy in the same cycle. If a command write arrives in that same cycle, the write decides busy.
- R6: A status read or a command write clears the latched interrupt, unless a completion or index event sets it in the same cycle.
- R7: A force-interrupt with bit 3 set raises a sticky interrupt. Status reads and later commands of other classes leave it asserted. A force-interrupt whose low nibble is 0 removes it.
- R8: A force-interrupt with bit 2 set while `drv_ready` is high arms a one-shot interrupt, which fires on the next rising edge of `drv_index`. If the drive is not ready, nothing is armed.
- R9: Every force-interrupt clears busy and DRQ. Low-nibble bits 0 and 1 have no effect on the interrupt.
- R10: Reset clears the interrupt and DRQ, sets the command to restore (0x03) with busy high, and holds `cmd_start` high until the first clock edge after reset.
- R11: `seq_drq_set` raises DRQ and `seq_drq_clr` lowers it. A clear beats a set, and a force-interrupt beats both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command byte |
| stat_re | input | 1 | Status read strobe |
| drv_index | input | 1 | Drive index pulse line |
| drv_trk0 | input | 1 | Drive at track zero |
| drv_hload | input | 1 | Drive head loaded |
| drv_wprot | input | 1 | Media write protected |
| drv_ready | input | 1 | Drive ready |
| seq_done | input | 1 | Command completion pulse from a sequencer |
| seq_drq_set | input | 1 | Raise data request |
| seq_drq_clr | input | 1 | Lower data request |
| err_crc | input | 1 | CRC error flag |
| err_seek | input | 1 | Seek error flag |
| err_lost | input | 1 | Lost data flag |
| err_rnf | input | 1 | Record not found flag |
| err_rtype | input | 1 | Record type flag |
| err_wprot | input | 1 | Write refused because protected |
| cmd_q | output | 8 | Held command byte |
| cmd_start | output | 1 | One-cycle start pulse for a non-interrupt command |
| busy | output | 1 | Command in progress |
| drq | output | 1 | Data request |
| stat_q | output | 8 | Captured status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default reset command of 0x03. It writes all 256 command bytes to cover the class decode. For each of the 16 upper nibbles, it then drives 64 combinations of the drive lines and error flags and compares every captured status byte with a model computed in the bench. That covers every class-dependent bit meaning under both DRQ levels. The bench then plays through the interrupt paths one at a time: completion, sticky immediate, arming on the index edge with the drive ready and not ready, and the condition bits that have no effect.

// File: rtl/fdc_status_pkg.sv
// Package: shared command classes and force-interrupt field positions.
// Assumes the command class is carried in the upper nibble of the byte.
package fdc_status_pkg;
    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int FI_IDX_BIT = 2;
    localparam int FI_IMM_BIT = 3;

    typedef enum logic [1:0] {
        CLS_STEP   = 2'd0,
        CLS_SECTOR = 2'd1,
        CLS_TRACK  = 2'd2,
        CLS_FORCE  = 2'd3
    } cmd_class_e;

    // Map an upper nibble to its command class.
    function automatic cmd_class_e classify(input logic [NIB_W-1:0] nib);
        if (!nib[3])           return CLS_STEP;
        else if (!nib[2])      return CLS_SECTOR;
        else if (nib == 4'hD)  return CLS_FORCE;
        else                   return CLS_TRACK;
    endfunction
endpackage

// File: rtl/fdc_cmd_reg.sv
// Command register: holds the command byte, decodes its class, and
// keeps the busy and DRQ flags. Assumes single-cycle strobes.
module fdc_cmd_reg
    import fdc_status_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_CMD = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              seq_done,
    input  logic              seq_drq_set,
    input  logic              seq_drq_clr,
    output logic [BYTE_W-1:0] cmd_q,
    output cmd_class_e        cls,
    output logic              force_we,
    output logic              busy,
    output logic              drq,
    output logic              cmd_start
);
    // Decode a force-interrupt write as it arrives.
    always_comb force_we = cmd_we && (classify(cmd_data[BYTE_W-1:BYTE_W-NIB_W]) == CLS_FORCE);

    // Class of the command currently held.
    always_comb cls = classify(cmd_q[BYTE_W-1:BYTE_W-NIB_W]);

    // Command byte storage; reset loads the restore command.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= RESET_CMD;
        else if (cmd_we) cmd_q <= cmd_data;
    end

    // Busy: set by a new non-interrupt command, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy <= 1'b1;
        else if (cmd_we)   busy <= !force_we;
        else if (seq_done) busy <= 1'b0;
    end

    // Start pulse; high out of reset for the automatic restore.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_start <= 1'b1;
        else        cmd_start <= cmd_we && !force_we;
    end

    // Data request: force-interrupt, then clear, then set.
    always_ff @(posedge clk) begin
        if (!rst_n)           drq <= 1'b0;
        else if (force_we)    drq <= 1'b0;
        else if (seq_drq_clr) drq <= 1'b0;
        else if (seq_drq_set) drq <= 1'b1;
    end
endmodule

// File: rtl/fdc_irq_ctl.sv
// Interrupt control: latched end-of-command interrupt, sticky immediate
// interrupt and a one-shot armed on the index line. Assumes drv_index is
// already synchronous to clk.
module fdc_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic stat_re,
    input  logic seq_done,
    input  logic force_we,
    input  logic fl_none,
    input  logic fl_idx,
    input  logic fl_imm,
    input  logic drv_index,
    input  logic drv_ready,
    output logic idx_fire,
    output logic imm_q,
    output logic irq
);
    logic idx_prev;
    logic arm_q;
    logic latch_q;

    // Rising index edge while armed.
    always_comb idx_fire = arm_q && drv_index && !idx_prev;

    // Previous index level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_prev <= 1'b0;
        else        idx_prev <= drv_index;
    end

    // Latched interrupt: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     latch_q <= 1'b0;
        else if (seq_done || idx_fire)  latch_q <= 1'b1;
        else if (cmd_we || stat_re)     latch_q <= 1'b0;
    end

    // Sticky immediate interrupt, controlled only by force-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)                  imm_q <= 1'b0;
        else if (force_we && fl_none) imm_q <= 1'b0;
        else if (force_we && fl_imm)  imm_q <= 1'b1;
    end

    // Index arming: every force-interrupt rewrites it; firing disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)        arm_q <= 1'b0;
        else if (force_we) arm_q <= fl_idx && drv_ready;
        else if (idx_fire) arm_q <= 1'b0;
    end

    // Request line.
    always_comb irq = latch_q || imm_q;
endmodule

// File: rtl/fdc_status_mux.sv
// Status builder: chooses the meaning of the shared bits from the
// command class and captures the byte on a read strobe.
module fdc_status_mux
    import fdc_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_re,
    input  cmd_class_e        cls,
    input  logic              busy,
    input  logic              drq,
    input  logic              drv_index,
    input  logic              drv_trk0,
    input  logic              drv_hload,
    input  logic              drv_wprot,
    input  logic              drv_ready,
    input  logic              err_crc,
    input  logic              err_seek,
    input  logic              err_lost,
    input  logic              err_rnf,
    input  logic              err_rtype,
    input  logic              err_wprot,
    output logic [BYTE_W-1:0] stat_q
);
    logic              drive_view;
    logic [BYTE_W-1:0] stat_d;

    // Stepping and force-interrupt classes show the drive lines.
    always_comb drive_view = (cls == CLS_STEP) || (cls == CLS_FORCE);

    // Build the byte from the view in force.
    always_comb begin
        stat_d    = '0;
        stat_d[0] = busy;
        stat_d[3] = err_crc;
        stat_d[7] = !drv_ready;
        if (drive_view) begin
            stat_d[1] = drv_index;
            stat_d[2] = drv_trk0;
            stat_d[4] = err_seek;
            stat_d[5] = drv_hload;
            stat_d[6] = drv_wprot;
        end else begin
            stat_d[1] = drq;
            stat_d[2] = err_lost;
            stat_d[4] = err_rnf;
            stat_d[5] = err_rtype;
            stat_d[6] = err_wprot;
        end
    end

    // Capture on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (stat_re) stat_q <= stat_d;
    end
endmodule

// File: rtl/fdc_status_irq.sv
// Top level: command register, status byte and interrupt request of a
// floppy controller. Assumes all inputs are synchronous to clk.
module fdc_status_irq
    import fdc_status_pkg::*;
#(
    parameter logic [7:0] RESET_CMD = 8'h03
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_data,
    input  logic       stat_re,
    input  logic       drv_index,
    input  logic       drv_trk0,
    input  logic       drv_hload,
    input  logic       drv_wprot,
    input  logic       drv_ready,
    input  logic       seq_done,
    input  logic       seq_drq_set,
    input  logic       seq_drq_clr,
    input  logic       err_crc,
    input  logic       err_seek,
    input  logic       err_lost,
    input  logic       err_rnf,
    input  logic       err_rtype,
    input  logic       err_wprot,
    output logic [7:0] cmd_q,
    output logic       cmd_start,
    output logic       busy,
    output logic       drq,
    output logic [7:0] stat_q,
    output logic       irq
);
    cmd_class_e cls;
    logic       force_we;
    logic       fl_none;
    logic       idx_fire;
    logic       imm_q;

    // Empty condition field of a force-interrupt byte.
    always_comb fl_none = (cmd_data[NIB_W-1:0] == '0);

    fdc_cmd_reg #(.RESET_CMD(RESET_CMD)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .seq_done(seq_done), .seq_drq_set(seq_drq_set), .seq_drq_clr(seq_drq_clr),
        .cmd_q(cmd_q), .cls(cls), .force_we(force_we), .busy(busy),
        .drq(drq), .cmd_start(cmd_start)
    );

    fdc_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .stat_re(stat_re),
        .seq_done(seq_done), .force_we(force_we), .fl_none(fl_none),
        .fl_idx(cmd_data[FI_IDX_BIT]), .fl_imm(cmd_data[FI_IMM_BIT]),
        .drv_index(drv_index), .drv_ready(drv_ready),
        .idx_fire(idx_fire), .imm_q(imm_q), .irq(irq)
    );

    fdc_status_mux u_stat (
        .clk(clk), .rst_n(rst_n), .stat_re(stat_re), .cls(cls), .busy(busy),
        .drq(drq), .drv_index(drv_index), .drv_trk0(drv_trk0),
        .drv_hload(drv_hload), .drv_wprot(drv_wprot), .drv_ready(drv_ready),
        .err_crc(err_crc), .err_seek(err_seek), .err_lost(err_lost),
        .err_rnf(err_rnf), .err_rtype(err_rtype), .err_wprot(err_wprot),
        .stat_q(stat_q)
    );
endmodule

// File: rtl/fdc_status_irq_chk.sv
// Checker: temporal properties of the status and interrupt block.
module fdc_status_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [7:0] cmd_data,
    input logic       stat_re,
    input logic       seq_done,
    input logic       drv_ready,
    input logic [7:0] cmd_q,
    input logic       cmd_start,
    input logic       busy,
    input logic       drq,
    input logic [7:0] stat_q,
    input logic       irq,
    input logic       idx_fire,
    input logic       imm_q
);
    p_cmd_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> cmd_q == $past(cmd_data));
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_data[7:4] != 4'hD |=> busy && cmd_start);
    p_ready_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_re |=> stat_q[7] == !$past(drv_ready) && stat_q[0] == $past(busy));
    p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done && !cmd_we |=> irq && !busy);
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_re && !seq_done && !idx_fire && !imm_q && !cmd_we |=> !irq);
    p_imm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        imm_q && !cmd_we |=> irq);
    p_idx_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fire |=> irq);
    p_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_data[7:4] == 4'hD |=> !busy && !drq);
endmodule

bind fdc_status_irq fdc_status_irq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .stat_re(stat_re), .seq_done(seq_done), .drv_ready(drv_ready),
    .cmd_q(cmd_q), .cmd_start(cmd_start), .busy(busy), .drq(drq),
    .stat_q(stat_q), .irq(irq), .idx_fire(idx_fire), .imm_q(imm_q)
);

// File: tb/fdc_status_irq_tb_top.sv
`timescale 1ns/1ps
module fdc_status_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 0, stat_re = 0;
    logic [7:0] cmd_data = 0;
    logic       drv_index = 0, drv_trk0 = 0, drv_hload = 0, drv_wprot = 0, drv_ready = 1;
    logic       seq_done = 0, seq_drq_set = 0, seq_drq_clr = 0;
    logic       err_crc = 0, err_seek = 0, err_lost = 0, err_rnf = 0, err_rtype = 0, err_wprot = 0;
    logic [7:0] cmd_q, stat_q;
    logic       cmd_start, busy, drq, irq;
    int         n_tests = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    fdc_status_irq dut_i (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); cmd_we = 1; cmd_data = b;
        @(negedge clk); cmd_we = 0;
    endtask

    task automatic rd();
        @(negedge clk); stat_re = 1;
        @(negedge clk); stat_re = 0;
    endtask

    task automatic drq_pulse(input bit set);
        @(negedge clk); seq_drq_set = set; seq_drq_clr = !set;
        @(negedge clk); seq_drq_set = 0; seq_drq_clr = 0;
    endtask

    task automatic done_pulse();
        @(negedge clk); seq_done = 1;
        @(negedge clk); seq_done = 0;
    endtask

    // Expected status from the bit assignment in the requirements.
    function automatic logic [7:0] exp_stat(input logic [3:0] nib, input logic b, input logic d);
        if (!nib[3] || nib == 4'hD)
            return {!drv_ready, drv_wprot, drv_hload, err_seek, err_crc, drv_trk0, drv_index, b};
        else
            return {!drv_ready, err_wprot, err_rtype, err_rnf, err_crc, err_lost, d, b};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values, start pulse held until the first edge
        check(cmd_q == 8'h03, "R10 cmd", cmd_q, 3);
        check(busy && cmd_start, "R10 busy/start", {busy, cmd_start}, 3);
        check(!irq && !drq, "R10 irq/drq", {irq, drq}, 0);
        rst_n = 1;
        check(cmd_start, "R10 start before edge", cmd_start, 1);
        @(negedge clk);
        check(!cmd_start, "R10 start one cycle", cmd_start, 0);

        // R5 completion then R6 read clear
        done_pulse();
        check(irq && !busy, "R5 done", {irq, busy}, 2);
        rd();
        check(!irq, "R6 read clears", irq, 0);
        done_pulse();
        wr(8'h10);
        check(!irq, "R6 command clears", irq, 0);

        // R1 all command bytes
        drv_index = 0; drv_ready = 1;
        for (int v = 0; v < 256; v++) begin
            wr(v[7:0]);
            check(cmd_q == v[7:0], "R1 load", cmd_q, v);
            check(cmd_start == (v[7:4] != 4'hD) && busy == (v[7:4] != 4'hD),
                  "R1 start/busy", {cmd_start, busy}, {2{v[7:4] != 4'hD}});
        end
        wr(8'hD0);

        // R2/R3/R4 sweep: every class nibble, 64 input patterns
        for (int n = 0; n < 16; n++) begin
            wr({n[3:0], 4'h0});
            drq_pulse(n[0]);
            for (int p = 0; p < 64; p++) begin
                drv_index = p[0]; drv_trk0 = p[1]; drv_hload = p[2]; drv_wprot = p[3];
                drv_ready = p[4]; err_crc = p[5]; err_seek = p[1] ^ p[3];
                err_lost = p[2] ^ p[0]; err_rnf = p[4] ^ p[5]; err_rtype = p[0] ^ p[5];
                err_wprot = p[3] ^ p[4];
                rd();
                check(stat_q == exp_stat(n[3:0], n != 13, n[0]),
                      (!n[3] || n == 13) ? "R3 drive view R2" : "R4 transfer view R2",
                      stat_q, exp_stat(n[3:0], n != 13, n[0]));
            end
        end
        drv_index = 0; drv_ready = 1;
        wr(8'hD0);

        // R11 drq set/clear and clear priority
        drq_pulse(1);
        check(drq, "R11 set", drq, 1);
        @(negedge clk); seq_drq_set = 1; seq_drq_clr = 1;
        @(negedge clk); seq_drq_set = 0; seq_drq_clr = 0;
        check(!drq, "R11 clear wins", drq, 0);

        // R7 sticky immediate interrupt
        wr(8'hD8);
        check(irq, "R7 immediate", irq, 1);
        rd();
        check(irq, "R7 survives read", irq, 1);
        wr(8'h03);
        check(irq, "R7 survives command", irq, 1);
        wr(8'hD0);
        check(!irq, "R7 cleared by D0", irq, 0);

        // R9 force clears busy and drq; bits 0,1 inert
        wr(8'h80); drq_pulse(1);
        wr(8'hD3);
        check(!busy && !drq, "R9 busy/drq", {busy, drq}, 0);
        check(!irq, "R9 bits0-1 no irq", irq, 0);
        drv_ready = 0; @(negedge clk); drv_ready = 1;
        repeat (2) @(negedge clk);
        check(!irq, "R9 ready edge no irq", irq, 0);

        // R8 index arming
        wr(8'hD4);
        check(!irq, "R8 armed quiet", irq, 0);
        drv_index = 1; @(negedge clk);
        check(irq, "R8 index fires", irq, 1);
        drv_index = 0; rd();
        drv_index = 1; @(negedge clk); drv_index = 0; @(negedge clk);
        check(!irq, "R8 one-shot", irq, 0);
        drv_ready = 0; wr(8'hD4);
        drv_index = 1; @(negedge clk); drv_index = 0; @(negedge clk);
        check(!irq, "R8 not ready no arm", irq, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule